// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute stage of a 32-bit integer data path. Each cycle it takes a register operand A, an already-expanded immediate operand B, the current N, Z, C and V condition flags, and the carry produced by the immediate expansion (with a bit that says whether that carry is meaningful). It applies one of seventeen data-processing operations: the sixteen classic ones and OR-NOT. One clock later it presents the 32-bit result, a register write enable and the next flag values.

The operations fall into two flag classes. Bitwise operations (including the moves and the two bitwise tests) refresh N and Z from the result. They take C from the expansion carry only when that carry is marked valid, and they never touch V. Adder operations, which include the reversed and carry-consuming subtracts and the two comparisons, produce all four flags from a single shared adder. The four test/compare operations always update the flags and never write a register.

Top module: `dp_alu_flags`

## Requirements
- R1: While `rst_n` is low, all outputs are zero (`result_o`, `wr_en_o`, `n_o`, `z_o`, `c_o`, `v_o`). This reset takes effect without waiting for a clock edge.
- R2: Outputs are registered. The values at the output reflect the inputs sampled at the previous rising clock edge.
- R3: Operation codes on `op_i`: 0 AND (A&B), 1 EOR (A^B), 2 SUB (A-B), 3 RSB, 4 ADD (A+B), 5 ADC, 6 SBC, 7 RSC, 8 TST (A&B), 9 TEQ (A^B), 10 CMP (A-B), 11 CMN (A+B), 12 ORR (A|B), 13 MOV (B), 14 BIC (A&~B), 15 MVN (~B), 16 ORN (A|~B). `result_o` carries the computed value for every one of these codes, the four test/compare codes included.
- R4: Adder operations with flag update: N is result bit 31 and Z is result==0. C is the carry out of bit 31 of the adder. For a subtract the adder computes X + ~Y + carry-in, so C=1 means no borrow. V=1 when both adder inputs have the same sign and the result sign differs from it.
- R5: ADC computes A+B+C. SBC computes A-B-(1-C). RSC computes B-A-(1-C). C here is the incoming carry flag `c_i`.
- R6: RSB computes B-A and RSC computes B-A-(1-C). Both reverse the operand order.
- R7: Bitwise operations with flag update set N and Z from the result. C becomes `shc_i` when `shc_valid_i` is 1, and otherwise keeps `c_i`. V always keeps `v_i`.
- R8: TST, TEQ, CMP and CMN update the flags whatever `set_flags_i` is, and they drive `wr_en_o` low. All other defined codes drive `wr_en_o` high.
- R9: For a non-compare operation with `set_flags_i` low, the flag outputs equal `n_i`, `z_i`, `c_i`, `v_i`.
- R10: Codes 17 to 31 are undefined. They produce `result_o`=0 and `wr_en_o`=0, and the flag outputs equal the flag inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code (see R3) |
| set_flags_i | input | 1 | Request a flag update |
| a_i | input | 32 | Register operand A |
| b_i | input | 32 | Expanded immediate operand B |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| shc_i | input | 1 | Carry out of the immediate expansion |
| shc_valid_i | input | 1 | `shc_i` is meaningful |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Register write request |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |

## Verification
Several properties are checked on every cycle against the inputs of the previous cycle: compare codes never write, undefined codes and a cleared set-flags request pass the flags through, bitwise operations keep V, and an updated Z always matches a zero result. The arithmetic itself can only be shown by the bench's vectors. Those vectors cover the values of C and V at signed overflow and borrow, reversed operands, the use of the incoming carry, and shifter-carry selection. The asynchronous effect of a reset in mid-run is also a bench-only scenario.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int DP_OPW = 5;

  typedef enum logic [DP_OPW-1:0] {
    OP_AND = 5'd0,  OP_EOR = 5'd1,  OP_SUB = 5'd2,  OP_RSB = 5'd3,
    OP_ADD = 5'd4,  OP_ADC = 5'd5,  OP_SBC = 5'd6,  OP_RSC = 5'd7,
    OP_TST = 5'd8,  OP_TEQ = 5'd9,  OP_CMP = 5'd10, OP_CMN = 5'd11,
    OP_ORR = 5'd12, OP_MOV = 5'd13, OP_BIC = 5'd14, OP_MVN = 5'd15,
    OP_ORN = 5'd16
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dp_flags_t;

  function automatic logic op_is_logic(input logic [DP_OPW-1:0] op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR,
      OP_MOV, OP_BIC, OP_MVN, OP_ORN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_arith(input logic [DP_OPW-1:0] op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_cmp(input logic [DP_OPW-1:0] op);
    case (op)
      OP_TST, OP_TEQ, OP_CMP, OP_CMN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DP_OPW-1:0] op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  output logic [DW-1:0]     res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_ORN:         res_o = a_i | ~b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_add_unit.sv
module dp_add_unit
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DP_OPW-1:0] op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic              cin_flag_i,
  output logic [DW-1:0]     sum_o,
  output logic              c_o,
  output logic              v_o
);
  logic [DW-1:0] x_op, y_op;
  logic          cin;
  logic [DW:0]   wide;

  // Operand steering: subtracts invert one side, reversed forms swap sides.
  always_comb begin
    case (op_i)
      OP_SUB, OP_CMP: begin x_op = a_i; y_op = ~b_i; cin = 1'b1;       end
      OP_RSB:         begin x_op = b_i; y_op = ~a_i; cin = 1'b1;       end
      OP_ADC:         begin x_op = a_i; y_op = b_i;  cin = cin_flag_i; end
      OP_SBC:         begin x_op = a_i; y_op = ~b_i; cin = cin_flag_i; end
      OP_RSC:         begin x_op = b_i; y_op = ~a_i; cin = cin_flag_i; end
      default:        begin x_op = a_i; y_op = b_i;  cin = 1'b0;       end
    endcase
  end

  assign wide  = {1'b0, x_op} + {1'b0, y_op} + {{DW{1'b0}}, cin};
  assign sum_o = wide[DW-1:0];
  assign c_o   = wide[DW];
  assign v_o   = (x_op[DW-1] == y_op[DW-1]) && (wide[DW-1] != x_op[DW-1]);
endmodule

// File: rtl/dp_flag_sel.sv
module dp_flag_sel
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          upd_i,
  input  logic          logic_cls_i,
  input  logic [DW-1:0] res_i,
  input  logic          add_c_i,
  input  logic          add_v_i,
  input  logic          shc_i,
  input  logic          shc_valid_i,
  input  dp_flags_t     old_i,
  output dp_flags_t     new_o
);
  always_comb begin
    new_o = old_i;
    if (upd_i) begin
      new_o.n = res_i[DW-1];
      new_o.z = (res_i == '0);
      if (logic_cls_i) begin
        if (shc_valid_i) new_o.c = shc_i;
      end else begin
        new_o.c = add_c_i;
        new_o.v = add_v_i;
      end
    end
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DP_OPW-1:0] op_i,
  input  logic              set_flags_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic              n_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic              v_i,
  input  logic              shc_i,
  input  logic              shc_valid_i,
  output logic [DW-1:0]     result_o,
  output logic              wr_en_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              v_o
);
  logic [DW-1:0] logic_res, add_res, res_nx;
  logic          add_c, add_v;
  logic          is_log, is_ari, is_cmp, known, upd, wr_nx;
  dp_flags_t     old_fl, fl_nx, fl_q;
  logic [DW-1:0] res_q;
  logic          wr_q, primed_q;

  dp_logic_unit #(.DW(DW)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(logic_res)
  );

  dp_add_unit #(.DW(DW)) u_add (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_flag_i(c_i),
    .sum_o(add_res), .c_o(add_c), .v_o(add_v)
  );

  // Next-state decode
  always_comb begin
    is_log = op_is_logic(op_i);
    is_ari = op_is_arith(op_i);
    is_cmp = op_is_cmp(op_i);
    known  = is_log | is_ari;
    upd    = known & (set_flags_i | is_cmp);
    wr_nx  = known & ~is_cmp;
    old_fl = '{n: n_i, z: z_i, c: c_i, v: v_i};
    if (is_log)      res_nx = logic_res;
    else if (is_ari) res_nx = add_res;
    else             res_nx = '0;
  end

  dp_flag_sel #(.DW(DW)) u_flags (
    .upd_i(upd), .logic_cls_i(is_log), .res_i(res_nx),
    .add_c_i(add_c), .add_v_i(add_v),
    .shc_i(shc_i), .shc_valid_i(shc_valid_i),
    .old_i(old_fl), .new_o(fl_nx)
  );

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '0;
      wr_q     <= 1'b0;
      fl_q     <= '0;
      primed_q <= 1'b0;
    end else begin
      res_q    <= res_nx;
      wr_q     <= wr_nx;
      fl_q     <= fl_nx;
      primed_q <= 1'b1;
    end
  end

  assign result_o = res_q;
  assign wr_en_o  = wr_q;
  assign n_o      = fl_q.n;
  assign z_o      = fl_q.z;
  assign c_o      = fl_q.c;
  assign v_o      = fl_q.v;

  // Checks against the inputs of the previous cycle
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && op_is_cmp($past(op_i))) |-> !wr_en_o);

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !$past(set_flags_i) && !op_is_cmp($past(op_i)))
      |-> ({n_o, z_o, c_o, v_o} == $past({n_i, z_i, c_i, v_i})));

  a_r7_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && op_is_logic($past(op_i))) |-> (v_o == $past(v_i)));

  a_r10_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !op_is_logic($past(op_i)) && !op_is_arith($past(op_i)))
      |-> (!wr_en_o && result_o == '0 &&
           {n_o, z_o, c_o, v_o} == $past({n_i, z_i, c_i, v_i})));

  a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && op_is_arith($past(op_i)) &&
     ($past(set_flags_i) || op_is_cmp($past(op_i))))
      |-> (z_o == (result_o == '0) && n_o == result_o[DW-1]));
endmodule

// File: tb/dp_alu_flags_bench.sv
module dp_alu_flags_bench;
  typedef struct packed {
    logic [4:0]  op;
    logic        sf;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fin;
    logic        shc;
    logic        shcv;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fout;
  } vec_t;

  localparam int NV = 20;
  // fin/fout are {N,Z,C,V}
  localparam vec_t VECS [NV] = '{
    '{5'd4,  1'b1, 32'h7FFFFFFF, 32'h00000001, 4'b0000, 1'b0, 1'b0, 32'h80000000, 1'b1, 4'b1001}, // R4 ADD overflow
    '{5'd2,  1'b1, 32'h00000005, 32'h00000005, 4'b0000, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R4 SUB equal
    '{5'd2,  1'b1, 32'h00000003, 32'h00000005, 4'b0000, 1'b0, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R4 SUB borrow
    '{5'd3,  1'b1, 32'h00000003, 32'h00000005, 4'b0000, 1'b0, 1'b0, 32'h00000002, 1'b1, 4'b0010}, // R6 RSB
    '{5'd5,  1'b1, 32'hFFFFFFFF, 32'h00000000, 4'b0010, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R5 ADC
    '{5'd6,  1'b1, 32'h00000010, 32'h00000003, 4'b0000, 1'b0, 1'b0, 32'h0000000C, 1'b1, 4'b0010}, // R5 SBC
    '{5'd7,  1'b1, 32'h00000001, 32'h00000000, 4'b0010, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R6 RSC
    '{5'd10, 1'b0, 32'h80000000, 32'h00000001, 4'b0000, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b0, 4'b0011}, // R8 CMP
    '{5'd11, 1'b0, 32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R8 CMN
    '{5'd0,  1'b1, 32'hF0F0F0F0, 32'hFF00FF00, 4'b0011, 1'b0, 1'b0, 32'hF000F000, 1'b1, 4'b1011}, // R7 AND
    '{5'd1,  1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0001, 1'b1, 1'b1, 32'h00000000, 1'b1, 4'b0111}, // R7 EOR
    '{5'd8,  1'b0, 32'h00000001, 32'h00000002, 4'b1000, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0100}, // R8 TST
    '{5'd9,  1'b0, 32'h80000000, 32'h00000000, 4'b0110, 1'b0, 1'b0, 32'h80000000, 1'b0, 4'b1010}, // R8 TEQ
    '{5'd12, 1'b0, 32'h0000000F, 32'h000000F0, 4'b1111, 1'b0, 1'b0, 32'h000000FF, 1'b1, 4'b1111}, // R9 ORR
    '{5'd16, 1'b1, 32'h00000000, 32'hFFFF0000, 4'b0000, 1'b0, 1'b0, 32'h0000FFFF, 1'b1, 4'b0000}, // R3 ORN
    '{5'd13, 1'b1, 32'h12345678, 32'h80000001, 4'b0100, 1'b1, 1'b1, 32'h80000001, 1'b1, 4'b1010}, // R3 MOV
    '{5'd14, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0001, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'b0101}, // R3 BIC
    '{5'd15, 1'b1, 32'h00000000, 32'hFFFFFFFF, 4'b1010, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R3 MVN
    '{5'd4,  1'b0, 32'hFFFFFFFF, 32'h00000001, 4'b1001, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'b1001}, // R9 ADD no flags
    '{5'd17, 1'b1, 32'h0000ABCD, 32'h00001234, 4'b0101, 1'b1, 1'b1, 32'h00000000, 1'b0, 4'b0101}  // R10 undefined
  };

  logic        clk, rst_n;
  logic [4:0]  op_i;
  logic        set_flags_i, n_i, z_i, c_i, v_i, shc_i, shc_valid_i;
  logic [31:0] a_i, b_i, result_o;
  logic        wr_en_o, n_o, z_o, c_o, v_o;
  int          checks, errors;
  logic        done;

  dp_alu_flags u_dp_alu_flags (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
    .a_i(a_i), .b_i(b_i), .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i),
    .shc_i(shc_i), .shc_valid_i(shc_valid_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual res=%h wr=%b nzcv=%b expected res=%h wr=%b nzcv=%b",
               req, act[37:6], act[5], act[3:0], exp[37:6], exp[5], exp[3:0]);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; set_flags_i = v.sf; a_i = v.a; b_i = v.b;
    {n_i, z_i, c_i, v_i} = v.fin; shc_i = v.shc; shc_valid_i = v.shcv;
  endtask

  function automatic logic [37:0] outs();
    return {result_o, wr_en_o, 1'b0, n_o, z_o, c_o, v_o};
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    op_i = 5'd0; set_flags_i = 1'b0; a_i = '0; b_i = '0;
    {n_i, z_i, c_i, v_i} = 4'b1111; shc_i = 1'b1; shc_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 38'd0);
    rst_n = 1'b1;

    // Vector table: drive at negedge, the registered output appears after one edge (R2)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R2 vector %0d", i), outs(),
            {VECS[i].res, VECS[i].wr, 1'b0, VECS[i].fout});
    end

    // R2: output must not change before the clock edge
    drive('{5'd4, 1'b1, 32'h1, 32'h1, 4'b0000, 1'b0, 1'b0, 32'h0, 1'b0, 4'b0000});
    #2;
    check("R2 holds until edge", outs(), {32'h0, 1'b0, 1'b0, 4'b0101});
    @(negedge clk);
    check("R4 ADD small", outs(), {32'h2, 1'b1, 1'b0, 4'b0000});

    // R7: logical op with flags set but carry invalid keeps C
    drive('{5'd12, 1'b1, 32'h0, 32'h0, 4'b1011, 1'b0, 1'b0, 32'h0, 1'b0, 4'b0000});
    @(negedge clk);
    check("R7 carry kept, shc invalid", outs(), {32'h0, 1'b1, 1'b0, 4'b0111});

    // R7: valid shifter carry 0 clears C on MVN
    drive('{5'd15, 1'b1, 32'h0, 32'h0, 4'b0010, 1'b0, 1'b1, 32'h0, 1'b0, 4'b0000});
    @(negedge clk);
    check("R7 carry from shifter", outs(), {32'hFFFFFFFF, 1'b1, 1'b0, 4'b1000});

    // R1: reset in mid-run clears outputs at once
    drive('{5'd13, 1'b1, 32'h0, 32'hDEADBEEF, 4'b0000, 1'b0, 1'b0, 32'h0, 1'b0, 4'b0000});
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R1 async reset", outs(), 38'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 MOV after reset", outs(), {32'hDEADBEEF, 1'b1, 1'b0, 4'b1000});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule